// File: doc/BRIEF.md
# Panel Supply and Initialization Sequencer

This block brings an organic display panel up and down in a safe order. It drives two supply enables, one for the driver's logic rail and one for the high-voltage panel rail. It waits out the charge and discharge delay between them, and it sends a fixed list of configuration command bytes to a downstream bus writer. The bytes leave through a byte port with a valid/ready handshake and a command/data flag. Each byte is held until the writer accepts it, and the sequence moves forward only on an accepted byte.

Three single-cycle requests drive the block. A start-up request takes it from the off state to the on state. A shut-down request takes it back to off. A refresh request, given while the panel is on, sends the configuration list again with both rails left alone, so that panel state corrupted by noise can be restored. Two status outputs report what the block is doing: one is high while a sequence is running, and the other is high while the panel is fully on. The settle delay is a clock count derived from the clock frequency and a delay in milliseconds. A short-delay switch replaces it with a small cycle count for simulation.

Top module: `panel_pwr_seq`

## Requirements
- R1: During and right after reset, logicEn, panelEn, cmdValid, busy and panelOn are all 0.
- R2: A upReq sampled in the off state sets logicEn on the next clock edge. From that cycle on, the byte 0xAE (display off) is offered, while panelEn stays 0.
- R3: Power-up sends 18 accepted bytes in this order: 0xAE, D3 00 A8 3F 40 A0 C8 DA 12 81 CONTRAST A4 A6 B0 00 10, and then 0xAF (display on). cmdIsData is 0 on every byte.
- R4: panelEn rises on the clock edge that accepts the last script byte (0x10). Display-on is first offered WAIT_CYCLES+1 cycles after panelEn rises. WAIT_CYCLES is SIM_CYCLES when SIM_SHORT=1, and (CLK_HZ/1000)*DELAY_MS otherwise.
- R5: busy is 1 from the first cycle of any sequence until its last byte or delay has finished. panelOn is 1 only in the on state, and the two are never 1 together. No byte is offered while busy is 0.
- R6: A byte offered with cmdReady low is offered again, unchanged, in the next cycle. The sequence advances only on a cycle with cmdValid and cmdReady both high.
- R7: A downReq in the on state offers 0xAE. panelEn falls on the edge that accepts it. logicEn falls WAIT_CYCLES+1 cycles after panelEn, and the block is then off and not busy.
- R8: A reinitReq in the on state sends the 16 script bytes D3 through 10 (no 0xAE or 0xAF) with both supplies held on, and then returns to the on state.
- R9: When downReq and reinitReq are sampled together in the on state, shut-down is taken and no script byte is sent.
- R10: Requests are ignored while busy is 1. upReq is ignored in the on state, and downReq and reinitReq are ignored in the off state.
- R11: The contrast byte after 0x81 equals the CONTRAST parameter, whose default is 0x80.
- R12: panelEn is never 1 while logicEn is 0, and 0xAF is offered only while both supplies are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReq | input | 1 | Start-up request |
| downReq | input | 1 | Shut-down request |
| reinitReq | input | 1 | Replay configuration list while on |
| logicEn | output | 1 | Logic rail enable |
| panelEn | output | 1 | Panel high-voltage rail enable |
| cmdValid | output | 1 | Command byte is offered |
| cmdReady | input | 1 | Bus writer accepts the offered byte |
| cmdByte | output | 8 | Offered byte |
| cmdIsData | output | 1 | Data/command flag, always 0 (command) |
| busy | output | 1 | A sequence is running |
| panelOn | output | 1 | Panel is powered and configured |

## Verification
The assertions check on every cycle the rules that hold in any state:
- the panel rail is never on without the logic rail;
- display-on is offered only with both rails on;
- a stalled byte stays stable;
- the panel rail switches only right after the right byte is accepted;
- the two status outputs never overlap.

Other behaviours can only be shown by the bench's scenarios:
- the full byte order of each sequence;
- the exact length of the settle delay;
- the request priority;
- requests that are ignored while busy or in the wrong state.

The bench runs these scenarios across several patterns of stalls by the downstream writer.

// File: rtl/pps_pkg.sv
`timescale 1ns/100ps
package pps_pkg;

  localparam int SCRIPT_LEN = 18;
  localparam int IDX_W      = $clog2(SCRIPT_LEN);

  localparam logic [IDX_W-1:0] IDX_OFF_CMD  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_FIRST    = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST     = IDX_W'(SCRIPT_LEN-2);
  localparam logic [IDX_W-1:0] IDX_ON_CMD   = IDX_W'(SCRIPT_LEN-1);

  localparam logic [7:0] CMD_DISP_OFF = 8'hAE;
  localparam logic [7:0] CMD_DISP_ON  = 8'hAF;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP_CMD,
    ST_UP_WAIT,
    ST_UP_ON,
    ST_ON,
    ST_REINIT,
    ST_DN_CMD,
    ST_DN_WAIT
  } seqState_t;

  typedef struct packed {
    logic             idxLoad;
    logic [IDX_W-1:0] idxVal;
    logic             idxInc;
    logic             timerStart;
    logic             logicSet;
    logic             logicClr;
    logic             panelSet;
    logic             panelClr;
  } seqStrobe_t;

  // Position 0 is display off, 1..16 is the configuration list,
  // the final entry is display on.
  function automatic logic [7:0] scriptByte(input logic [IDX_W-1:0] idx,
                                            input logic [7:0] contrast);
    logic [7:0] b;
    case (idx)
      5'd0:    b = CMD_DISP_OFF;
      5'd1:    b = 8'hD3;
      5'd2:    b = 8'h00;
      5'd3:    b = 8'hA8;
      5'd4:    b = 8'h3F;
      5'd5:    b = 8'h40;
      5'd6:    b = 8'hA0;
      5'd7:    b = 8'hC8;
      5'd8:    b = 8'hDA;
      5'd9:    b = 8'h12;
      5'd10:   b = 8'h81;
      5'd11:   b = contrast;
      5'd12:   b = 8'hA4;
      5'd13:   b = 8'hA6;
      5'd14:   b = 8'hB0;
      5'd15:   b = 8'h00;
      5'd16:   b = 8'h10;
      5'd17:   b = CMD_DISP_ON;
      default: b = CMD_DISP_OFF;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pps_datapath.sv
`timescale 1ns/100ps
module pps_datapath
  import pps_pkg::*;
#(
  parameter int         WAIT_CYCLES = 16,
  parameter int         CNT_W       = 5,
  parameter logic [7:0] CONTRAST    = 8'h80
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       stb,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       cmdByte,
  output logic             timerDone,
  output logic             logicEn,
  output logic             panelEn
);

  logic [CNT_W-1:0] waitCnt;

  // Script position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx <= IDX_OFF_CMD;
    end else if (stb.idxLoad) begin
      idx <= stb.idxVal;
    end else if (stb.idxInc) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assign cmdByte = scriptByte(idx, CONTRAST);

  // Settle delay down-counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (stb.timerStart) begin
      waitCnt <= CNT_W'(WAIT_CYCLES);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - CNT_W'(1);
    end
  end

  assign timerDone = (waitCnt == '0);

  // Supply enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      logicEn <= 1'b0;
      panelEn <= 1'b0;
    end else begin
      if (stb.logicSet)      logicEn <= 1'b1;
      else if (stb.logicClr) logicEn <= 1'b0;
      if (stb.panelSet)      panelEn <= 1'b1;
      else if (stb.panelClr) panelEn <= 1'b0;
    end
  end

endmodule

// File: rtl/pps_ctrl.sv
`timescale 1ns/100ps
module pps_ctrl
  import pps_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             upReq,
  input  logic             downReq,
  input  logic             reinitReq,
  input  logic             cmdReady,
  input  logic [IDX_W-1:0] idx,
  input  logic             timerDone,
  output seqStrobe_t       stb,
  output logic             cmdValid,
  output logic             busy,
  output logic             panelOn
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    cmdValid = 1'b0;
    case (state)
      ST_OFF: begin
        if (upReq) begin
          stb.logicSet = 1'b1;
          stb.idxLoad  = 1'b1;
          stb.idxVal   = IDX_OFF_CMD;
          stateNxt     = ST_UP_CMD;
        end
      end
      ST_UP_CMD: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          if (idx == IDX_LAST) begin
            stb.panelSet   = 1'b1;
            stb.timerStart = 1'b1;
            stateNxt       = ST_UP_WAIT;
          end else begin
            stb.idxInc = 1'b1;
          end
        end
      end
      ST_UP_WAIT: begin
        if (timerDone) begin
          stb.idxLoad = 1'b1;
          stb.idxVal  = IDX_ON_CMD;
          stateNxt    = ST_UP_ON;
        end
      end
      ST_UP_ON: begin
        cmdValid = 1'b1;
        if (cmdReady) stateNxt = ST_ON;
      end
      ST_ON: begin
        if (downReq) begin
          stb.idxLoad = 1'b1;
          stb.idxVal  = IDX_OFF_CMD;
          stateNxt    = ST_DN_CMD;
        end else if (reinitReq) begin
          stb.idxLoad = 1'b1;
          stb.idxVal  = IDX_FIRST;
          stateNxt    = ST_REINIT;
        end
      end
      ST_REINIT: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          if (idx == IDX_LAST) stateNxt   = ST_ON;
          else                 stb.idxInc = 1'b1;
        end
      end
      ST_DN_CMD: begin
        cmdValid = 1'b1;
        if (cmdReady) begin
          stb.panelClr   = 1'b1;
          stb.timerStart = 1'b1;
          stateNxt       = ST_DN_WAIT;
        end
      end
      ST_DN_WAIT: begin
        if (timerDone) begin
          stb.logicClr = 1'b1;
          stateNxt     = ST_OFF;
        end
      end
      default: stateNxt = ST_OFF;
    endcase
  end

  assign busy    = (state != ST_OFF) && (state != ST_ON);
  assign panelOn = (state == ST_ON);

endmodule

// File: rtl/panel_pwr_seq.sv
`timescale 1ns/100ps
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int         CLK_HZ     = 50_000_000,
  parameter int         DELAY_MS   = 100,
  parameter bit         SIM_SHORT  = 1'b0,
  parameter int         SIM_CYCLES = 16,
  parameter logic [7:0] CONTRAST   = 8'h80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       upReq,
  input  logic       downReq,
  input  logic       reinitReq,
  output logic       logicEn,
  output logic       panelEn,
  output logic       cmdValid,
  input  logic       cmdReady,
  output logic [7:0] cmdByte,
  output logic       cmdIsData,
  output logic       busy,
  output logic       panelOn
);

  localparam int WAIT_CYCLES = SIM_SHORT ? SIM_CYCLES : (CLK_HZ / 1000) * DELAY_MS;
  localparam int CNT_W       = $clog2(WAIT_CYCLES + 1);

  seqStrobe_t       stb;
  logic [IDX_W-1:0] idx;
  logic             timerDone;

  pps_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .upReq     (upReq),
    .downReq   (downReq),
    .reinitReq (reinitReq),
    .cmdReady  (cmdReady),
    .idx       (idx),
    .timerDone (timerDone),
    .stb       (stb),
    .cmdValid  (cmdValid),
    .busy      (busy),
    .panelOn   (panelOn)
  );

  pps_datapath #(
    .WAIT_CYCLES (WAIT_CYCLES),
    .CNT_W       (CNT_W),
    .CONTRAST    (CONTRAST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .idx       (idx),
    .cmdByte   (cmdByte),
    .timerDone (timerDone),
    .logicEn   (logicEn),
    .panelEn   (panelEn)
  );

  assign cmdIsData = 1'b0;

endmodule

// File: rtl/pps_checker.sv
`timescale 1ns/100ps
module pps_checker (
  input logic       clk,
  input logic       rstN,
  input logic       logicEn,
  input logic       panelEn,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic [7:0] cmdByte,
  input logic       cmdIsData,
  input logic       busy,
  input logic       panelOn
);

  AST_PANEL_NEEDS_LOGIC: assert property (@(posedge clk) disable iff (!rstN)
    panelEn |-> logicEn); // R12

  AST_ON_NEEDS_SUPPLIES: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdByte == 8'hAF) |-> (panelEn && logicEn)); // R12

  AST_CMD_FLAG_LOW: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !cmdIsData); // R3

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdByte))); // R6

  AST_PANEL_UP_AFTER_SCRIPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(panelEn) |-> $past(cmdValid && cmdReady && cmdByte == 8'h10)); // R4

  AST_PANEL_CUT_AFTER_OFF: assert property (@(posedge clk) disable iff (!rstN)
    $fell(panelEn) |-> $past(cmdValid && cmdReady && cmdByte == 8'hAE)); // R7

  AST_LOGIC_DROP_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $fell(logicEn) |-> (!panelEn && !$past(panelEn))); // R7

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && panelOn)); // R5

  AST_NO_OFFER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid); // R5

endmodule

bind panel_pwr_seq pps_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .logicEn   (logicEn),
  .panelEn   (panelEn),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdByte   (cmdByte),
  .cmdIsData (cmdIsData),
  .busy      (busy),
  .panelOn   (panelOn)
);

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/100ps
module tb_panel_pwr_seq;

  localparam int W = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       upReq = 1'b0, downReq = 1'b0, reinitReq = 1'b0;
  logic       cmdReady = 1'b1;
  logic       logicEn, panelEn, cmdValid, cmdIsData, busy, panelOn;
  logic [7:0] cmdByte;

  int checks = 0, errors = 0;
  int stall = 0;
  int cyc = 0;
  logic [7:0] logB [0:63];
  logic       logD [0:63];
  int logN = 0;
  int lastHs = 0, panelRise = 0, panelFall = 0, logicFall = 0, afFirst = 0, riseGap = 0;
  int supplyDrops = 0;
  logic prevValid = 1'b0, prevReady = 1'b0, prevPanel = 1'b0, prevLogic = 1'b0;
  logic [7:0] prevByte = 8'h00;

  always #2.5 clk = ~clk; // 200 MHz

  panel_pwr_seq #(.SIM_SHORT(1'b1), .SIM_CYCLES(W)) dut (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq), .reinitReq(reinitReq),
    .logicEn(logicEn), .panelEn(panelEn), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdByte(cmdByte), .cmdIsData(cmdIsData), .busy(busy), .panelOn(panelOn));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expUp(input int i);
    case (i)
      0: return 8'hAE;  1: return 8'hD3;  2: return 8'h00;  3: return 8'hA8;
      4: return 8'h3F;  5: return 8'h40;  6: return 8'hA0;  7: return 8'hC8;
      8: return 8'hDA;  9: return 8'h12; 10: return 8'h81; 11: return 8'h80;
     12: return 8'hA4; 13: return 8'hA6; 14: return 8'hB0; 15: return 8'h00;
     16: return 8'h10; default: return 8'hAF;
    endcase
  endfunction

  // Ready pattern and monitor: inputs change on the falling edge, sampled 1 ns later
  always begin
    @(negedge clk);
    cyc++;
    cmdReady = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == 0);
    #1;
    if (rstN) begin
      if (prevValid && !prevReady)
        chk(cmdValid && cmdByte == prevByte, "R6 stalled byte held", cmdByte, prevByte);
      if (cmdValid && cmdReady) begin
        if (logN < 64) begin
          logB[logN] = cmdByte;
          logD[logN] = cmdIsData;
        end
        logN++;
        lastHs = cyc;
      end
      if (cmdValid && cmdByte == 8'hAF && !(prevValid && prevByte == 8'hAF)) afFirst = cyc;
      if (panelEn && !prevPanel) begin
        panelRise = cyc;
        riseGap = cyc - lastHs;
      end
      if (!panelEn && prevPanel) panelFall = cyc;
      if (!logicEn && prevLogic) logicFall = cyc;
      if (panelEn && !logicEn) chk(1'b0, "R12 panel without logic", panelEn, 0);
      if (cmdValid && cmdByte == 8'hAF && !(panelEn && logicEn))
        chk(1'b0, "R12 display-on without supplies", {panelEn, logicEn}, 3);
      if (busy && panelOn) chk(1'b0, "R5 busy and on together", 1, 0);
      if (cmdValid && !busy) chk(1'b0, "R5 offer while idle", 1, 0);
      if ((prevPanel && !panelEn) || (prevLogic && !logicEn)) supplyDrops++;
    end
    prevValid = cmdValid;
    prevReady = cmdReady;
    prevByte  = cmdByte;
    prevPanel = panelEn;
    prevLogic = logicEn;
  end

  task automatic pulse(input bit u, input bit d, input bit r);
    @(negedge clk);
    upReq = u; downReq = d; reinitReq = r;
    @(negedge clk);
    upReq = 1'b0; downReq = 1'b0; reinitReq = 1'b0;
    #2;
  endtask

  task automatic waitOn();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #2;
      if (panelOn) break;
    end
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #2;
      if (!busy) break;
    end
  endtask

  task automatic clearLog();
    logN = 0;
  endtask

  task automatic checkUpLog(input string tag);
    chk(logN == 18, {tag, " R3 byte count"}, logN, 18);
    for (int i = 0; i < 18 && i < logN; i++) begin
      chk(logB[i] == expUp(i), {tag, " R3 byte order"}, logB[i], expUp(i));
      chk(logD[i] == 1'b0, {tag, " R3 command flag"}, logD[i], 0);
    end
    if (logN > 11) chk(logB[11] == 8'h80, {tag, " R11 contrast byte"}, logB[11], 8'h80);
    chk(riseGap == 1, {tag, " R4 panel after last script byte"}, riseGap, 1);
    chk(afFirst - panelRise == W + 1, {tag, " R4 settle delay"}, afFirst - panelRise, W + 1);
    chk(panelOn && !busy && logicEn && panelEn, {tag, " R5 on status"},
        {panelOn, busy, logicEn, panelEn}, 4'b1011);
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #2;
    chk({logicEn, panelEn, cmdValid, busy, panelOn} == 5'b0, "R1 in reset",
        {logicEn, panelEn, cmdValid, busy, panelOn}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #2;
    chk({logicEn, panelEn, cmdValid, busy, panelOn} == 5'b0, "R1 after reset",
        {logicEn, panelEn, cmdValid, busy, panelOn}, 0);

    // R10: requests that do not apply in the off state
    clearLog();
    pulse(1'b0, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    #2;
    chk(!logicEn && !busy && logN == 0, "R10 down/refresh ignored when off",
        {logicEn, busy}, 0);

    // Sweep of writer stall patterns
    for (int s = 0; s < 4; s++) begin
      stall = s;
      clearLog();
      pulse(1'b1, 1'b0, 1'b0);
      chk(logicEn && !panelEn && cmdValid && cmdByte == 8'hAE && busy,
          "R2 start-up entry", {logicEn, panelEn, cmdByte}, {2'b10, 8'hAE});
      waitOn();
      checkUpLog("up");

      // R10: upReq while on does nothing
      clearLog();
      pulse(1'b1, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      #2;
      chk(panelOn && !busy && logN == 0, "R10 upReq ignored when on", logN, 0);

      // R8 refresh
      clearLog();
      supplyDrops = 0;
      pulse(1'b0, 1'b0, 1'b1);
      chk(busy, "R5 busy during refresh", busy, 1);
      waitOn();
      chk(logN == 16, "R8 refresh byte count", logN, 16);
      for (int i = 0; i < 16 && i < logN; i++)
        chk(logB[i] == expUp(i + 1), "R8 refresh byte", logB[i], expUp(i + 1));
      chk(supplyDrops == 0 && logicEn && panelEn, "R8 supplies held", supplyDrops, 0);

      // R7 shut-down
      clearLog();
      pulse(1'b0, 1'b1, 1'b0);
      waitIdle();
      chk(logN == 1 && logB[0] == 8'hAE, "R7 display-off sent", logB[0], 8'hAE);
      chk(logicFall - panelFall == W + 1, "R7 discharge delay", logicFall - panelFall, W + 1);
      chk(panelFall == lastHs + 1, "R7 panel cut after display-off", panelFall, lastHs + 1);
      chk(!logicEn && !panelEn && !panelOn && !busy, "R7 off state",
          {logicEn, panelEn, panelOn, busy}, 0);
    end

    // R9 priority and R10 requests during a running sequence
    stall = 1;
    clearLog();
    pulse(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse(1'b0, 1'b1, 1'b1);
    pulse(1'b1, 1'b0, 1'b0);
    waitOn();
    checkUpLog("R10 busy requests ignored");
    clearLog();
    pulse(1'b0, 1'b1, 1'b1);
    waitIdle();
    chk(logN == 1 && logB[0] == 8'hAE, "R9 shut-down wins", logN, 1);
    chk(!logicEn && !panelOn, "R9 ends off", logicEn, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule